// File: doc/BRIEF.md
# Single-Operand Arithmetic Unit with Implicit Temp

This block is the execute stage of an accumulator-style datapath in which every instruction names only one register. The second operand is always an implicit temp value. Each issued operation combines the named register with temp, produces a 32-bit result, and produces new zero and carry flags. Register storage, instruction decode and the flag register itself stay outside: the caller supplies both operands and the current carry, and takes back the result, a write strobe for the named register and a flag-update strobe.

Subtraction is offered in both directions against temp, and a compare performs the subtraction only for its flags. Single-bit shifts report the bit that falls out in carry. The two carry rotates feed the old carry in at one end and the bit leaving the other end out to carry. A plain rotate takes its distance from the low five bits of temp. Every output is registered, so the outputs for an operation issued on one rising edge are present after that edge and stay until the next issue.

Top module: `tmp_alu`

## Requirements
- R1: Opcode 0 (add) gives named + temp and opcode 1 (add with carry) gives named + temp + carry_i. Carry out is bit 32 of the 33-bit sum.
- R2: Opcode 2 (subtract) gives named - temp and opcode 5 (subtract with borrow) gives named - temp - carry_i. Carry out is 1 exactly when a borrow occurs, that is, when the unsigned subtrahend total exceeds named.
- R3: Opcode 3 (reverse subtract) gives temp - named. Carry out is 1 exactly when named > temp, unsigned.
- R4: Opcode 4 (compare) computes the flags of named - temp exactly as R2 does. It holds wr_en_o low and flag_en_o high, and result_o keeps its previous value.
- R5: Opcodes 6, 7 and 8 give named AND, OR and XOR temp. Carry out equals carry_i.
- R6: Opcode 9 shifts named left by one and fills bit 0 with zero. Carry out is the old bit 31.
- R7: Opcode 10 shifts named right by one and copies bit 31 into bit 31. Opcode 11 shifts named right by one and puts zero in bit 31. In both cases carry out is the old bit 0.
- R8: Opcode 12 rotates named left by temp[4:0] places. A count of 0 leaves the value unchanged. Carry out equals carry_i.
- R9: Opcode 13 gives {named[30:0], carry_i} with carry out named[31]. Opcode 14 gives {carry_i, named[31:1]} with carry out named[0].
- R10: zero_o is 1 exactly when the 32-bit outcome of the last flag-setting operation is all zeros. For compare, that outcome is the difference.
- R11: The outputs for an operation appear after the rising edge that samples issue_i high. When issue_i is low on an edge, wr_en_o and flag_en_o are low after it, and result_o, zero_o and carry_o hold their values.
- R12: Opcode 15 is reserved. When it is issued, wr_en_o and flag_en_o are low after the edge, and result_o, zero_o and carry_o hold their values.
- R13: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation valid this cycle |
| op_i | input | 4 | Operation code (see R1 to R12) |
| reg_i | input | 32 | Value of the named register |
| tmp_i | input | 32 | Value of the implicit temp register |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Write the result to the named register |
| flag_en_o | output | 1 | Load zero_o and carry_o into the flag register |
| zero_o | output | 1 | New zero flag |
| carry_o | output | 1 | New carry or borrow flag |

## Verification
The hardest cases to reach are the ones where the carry input and an operand extreme interact. Examples are subtract with borrow of equal operands with carry_i set, which must borrow and give all ones, and add with carry of all ones plus zero with carry_i set, which must wrap to zero with both flags set. A compare that must leave a previously written result untouched is in the same group. Random operands almost never hit these. The stimulus therefore runs a directed table of operand pairs drawn from 0, 1, all ones and the sign bit. Each pair is applied for every opcode and with both carry values. Random words follow, interleaved with idle cycles and reserved opcodes so that the hold behaviour is exercised between real operations.

// File: rtl/tmp_alu_pkg.sv
package tmp_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_CMP = 4'd4,  OP_SBC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
    OP_XOR = 4'd8,  OP_SHL = 4'd9,  OP_ASR = 4'd10, OP_LSR = 4'd11,
    OP_ROT = 4'd12, OP_RLC = 4'd13, OP_RRC = 4'd14, OP_RSV = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
           (op == OP_RSB) || (op == OP_CMP) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_shift(alu_op_e op);
    return (op == OP_SHL) || (op == OP_ASR) || (op == OP_LSR) ||
           (op == OP_ROT) || (op == OP_RLC) || (op == OP_RRC);
  endfunction

  function automatic logic op_sets_flags(alu_op_e op);
    return op != OP_RSV;
  endfunction

  function automatic logic op_writes(alu_op_e op);
    return (op != OP_RSV) && (op != OP_CMP);
  endfunction
endpackage

// File: rtl/tmp_alu_addsub.sv
module tmp_alu_addsub
  import tmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   nam,
  input  logic [DW-1:0]   tmp,
  input  logic            cin,
  output logic [DW-1:0]   sum,
  output logic            cout,
  output logic            hit
);
  localparam int SW = DW + 1;

  logic [DW-1:0] lhs, rhs;
  logic          inj;
  logic          negate;
  logic [SW-1:0] raw;

  // Every arithmetic form reduces to lhs + rhs + inj on one adder.
  always_comb begin
    lhs    = nam;
    rhs    = tmp;
    inj    = 1'b0;
    negate = 1'b0;
    unique case (op)
      OP_ADD: ;
      OP_ADC: inj = cin;
      OP_SUB, OP_CMP: begin rhs = ~tmp; inj = 1'b1; negate = 1'b1; end
      OP_SBC: begin rhs = ~tmp; inj = ~cin; negate = 1'b1; end
      OP_RSB: begin lhs = tmp; rhs = ~nam; inj = 1'b1; negate = 1'b1; end
      default: ;
    endcase
  end

  assign raw  = {1'b0, lhs} + {1'b0, rhs} + {{DW{1'b0}}, inj};
  assign sum  = raw[DW-1:0];
  // Subtracting forms report borrow, the complement of the adder carry.
  assign cout = negate ? ~raw[DW] : raw[DW];
  assign hit  = op_is_arith(op);
endmodule

// File: rtl/tmp_alu_logic.sv
module tmp_alu_logic
  import tmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] nam,
  input  logic [DW-1:0] tmp,
  output logic [DW-1:0] res,
  output logic          hit
);
  always_comb begin
    unique case (op)
      OP_AND:  res = nam & tmp;
      OP_OR:   res = nam | tmp;
      OP_XOR:  res = nam ^ tmp;
      default: res = '0;
    endcase
  end
  assign hit = op_is_logic(op);
endmodule

// File: rtl/tmp_alu_shift.sv
module tmp_alu_shift
  import tmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] nam,
  input  logic [DW-1:0] tmp,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          hit
);
  localparam int CW = $clog2(DW);

  // Log-depth left rotator driven by the low bits of temp.
  logic [DW-1:0] stg [0:CW];
  assign stg[0] = nam;

  for (genvar k = 0; k < CW; k++) begin : g_rot
    localparam int SH = 1 << k;
    assign stg[k+1] = tmp[k] ? {stg[k][DW-SH-1:0], stg[k][DW-1:DW-SH]}
                             : stg[k];
  end

  always_comb begin
    res  = nam;
    cout = cin;
    unique case (op)
      OP_SHL: begin res = {nam[DW-2:0], 1'b0};     cout = nam[DW-1]; end
      OP_ASR: begin res = {nam[DW-1], nam[DW-1:1]}; cout = nam[0];   end
      OP_LSR: begin res = {1'b0, nam[DW-1:1]};      cout = nam[0];   end
      OP_ROT: begin res = stg[CW];                  cout = cin;      end
      OP_RLC: begin res = {nam[DW-2:0], cin};       cout = nam[DW-1]; end
      OP_RRC: begin res = {cin, nam[DW-1:1]};       cout = nam[0];   end
      default: ;
    endcase
  end
  assign hit = op_is_shift(op);
endmodule

// File: rtl/tmp_alu.sv
module tmp_alu
  import tmp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] tmp_i,
  input  logic          carry_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic          flag_en_o,
  output logic          zero_o,
  output logic          carry_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DW-1:0] as_res, lg_res, sh_res;
  logic          as_c, sh_c;
  logic          as_hit, lg_hit, sh_hit;

  tmp_alu_addsub #(.DW(DW)) u_addsub (
    .op(op), .nam(reg_i), .tmp(tmp_i), .cin(carry_i),
    .sum(as_res), .cout(as_c), .hit(as_hit));

  tmp_alu_logic #(.DW(DW)) u_logic (
    .op(op), .nam(reg_i), .tmp(tmp_i), .res(lg_res), .hit(lg_hit));

  tmp_alu_shift #(.DW(DW)) u_shift (
    .op(op), .nam(reg_i), .tmp(tmp_i), .cin(carry_i),
    .res(sh_res), .cout(sh_c), .hit(sh_hit));

  // Named internal events for the checks below.
  logic          ev_take;
  logic          ev_write;
  logic [DW-1:0] nx_res;
  alu_flags_t    nx_flags;

  assign ev_take  = issue_i && op_sets_flags(op);
  assign ev_write = issue_i && op_writes(op);

  always_comb begin
    nx_res   = '0;
    nx_flags = '{zero: 1'b0, carry: carry_i};
    if (as_hit) begin
      nx_res         = as_res;
      nx_flags.carry = as_c;
    end else if (lg_hit) begin
      nx_res = lg_res;
    end else if (sh_hit) begin
      nx_res         = sh_res;
      nx_flags.carry = sh_c;
    end
    nx_flags.zero = (nx_res == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      flag_en_o <= 1'b0;
      zero_o    <= 1'b0;
      carry_o   <= 1'b0;
    end else begin
      wr_en_o   <= ev_write;
      flag_en_o <= ev_take;
      if (ev_write) result_o <= nx_res;
      if (ev_take) begin
        zero_o  <= nx_flags.zero;
        carry_o <= nx_flags.carry;
      end
    end
  end

  // R11: a register write always comes with a flag update
  p_write_has_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> flag_en_o);

  // R11: idle cycle leaves outputs quiet and held
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wr_en_o && !flag_en_o && $stable(result_o) &&
                  $stable(zero_o) && $stable(carry_o)));

  // R4: compare updates flags but never writes
  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 4'd4) |=> (!wr_en_o && flag_en_o && $stable(result_o)));

  // R12: reserved code changes nothing
  p_reserved_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 4'd15) |=> (!flag_en_o && $stable(zero_o) && $stable(carry_o)));

  // R5: logic operations pass the carry through
  p_logic_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i >= 4'd6 && op_i <= 4'd8) |=> (carry_o == $past(carry_i)));

  // R8: plain rotate passes the carry through
  p_rot_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 4'd12) |=> (carry_o == $past(carry_i)));

  // R10: a written result and its zero flag agree
  p_zero_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (zero_o == (result_o == '0)));

  // R6: shift left always clears bit 0
  p_shl_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 4'd9) |=> (result_o[0] == 1'b0));
endmodule

// File: tb/tmp_alu_tb.sv
`timescale 1ns/1ps
module tmp_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] reg_i = '0;
  logic [31:0] tmp_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o, flag_en_o, zero_o, carry_o;

  always #2.5 clk = ~clk;

  tmp_alu u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .reg_i(reg_i), .tmp_i(tmp_i), .carry_i(carry_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flag_en_o(flag_en_o),
    .zero_o(zero_o), .carry_o(carry_o));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference state
  logic [31:0] e_res = '0;
  bit e_we = 0, e_fe = 0, e_z = 0, e_c = 0;
  string e_tag = "R13";

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R1";
      2, 5: return "R2";
      3:    return "R3";
      4:    return "R4";
      6, 7, 8: return "R5";
      9:    return "R6";
      10, 11: return "R7";
      12:   return "R8";
      13, 14: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(e_tag, "result", longint'(result_o), longint'(e_res));
    chk(e_tag == "R13" ? "R13" : "R11", "wr_en", longint'(wr_en_o), longint'(e_we));
    chk(e_tag == "R13" ? "R13" : "R11", "flag_en", longint'(flag_en_o), longint'(e_fe));
    chk(e_tag == "R13" ? "R13" : "R10", "zero", longint'(zero_o), longint'(e_z));
    chk(e_tag, "carry", longint'(carry_o), longint'(e_c));
  endtask

  // Behavioural model on wide integers.
  task automatic model(int op, logic [31:0] a, logic [31:0] b, bit cin,
                       output logic [31:0] r, output bit c);
    longint unsigned ua = a, ub = b, t;
    r = '0; c = cin;
    case (op)
      0: begin t = ua + ub;       r = t[31:0]; c = t[32]; end
      1: begin t = ua + ub + cin; r = t[31:0]; c = t[32]; end
      2, 4: begin r = a - b; c = (ua < ub); end
      5: begin r = a - b - 32'(cin); c = (ua < ub + cin); end
      3: begin r = b - a; c = (ub < ua); end
      6: r = a & b;
      7: r = a | b;
      8: r = a ^ b;
      9: begin r = a << 1; c = a[31]; end
      10: begin r = 32'($signed(a) >>> 1); c = a[0]; end
      11: begin r = a >> 1; c = a[0]; end
      12: begin
        r = a;
        for (int i = 0; i < int'(b[4:0]); i++) r = (r << 1) | (r >> 31);
      end
      13: begin r = (a << 1) | 32'(cin); c = a[31]; end
      14: begin r = (a >> 1) | (32'(cin) << 31); c = a[0]; end
      default: ;
    endcase
  endtask

  // One operation: check previous, drive new, predict.
  task automatic step(bit iss, int op, logic [31:0] a, logic [31:0] b, bit cin);
    logic [31:0] r;
    bit c;
    @(negedge clk);
    check_all();
    issue_i = iss; op_i = 4'(op); reg_i = a; tmp_i = b; carry_i = cin;
    model(op, a, b, cin, r, c);
    e_we = iss && op != 15 && op != 4;
    e_fe = iss && op != 15;
    if (!iss) e_tag = "R11";
    else e_tag = tag_of(op);
    if (e_we) e_res = r;
    if (e_fe) begin e_z = (r == 0); e_c = c; end
  endtask

  logic [31:0] corners [0:5];

  initial begin
    corners[0] = 32'h0;        corners[1] = 32'h1;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_001F;
    repeat (3) @(negedge clk);
    check_all();            // R13 reset values
    check_all();
    rst_n = 1'b1;
    // Directed: R1 wrap to zero, R2 equal borrow with carry, R4 keep result
    step(1, 0, 32'hFFFF_FFFF, 32'h1, 0);
    step(1, 1, 32'hFFFF_FFFF, 32'h0, 1);
    step(1, 5, 32'h1234, 32'h1234, 1);
    step(1, 7, 32'hA5A5_0000, 32'h0000_5A5A, 1);
    step(1, 4, 32'h10, 32'h10, 0);   // R4 and R10: zero set, result held
    step(1, 3, 32'h5, 32'h3, 0);     // R3 borrow
    step(1, 12, 32'h8000_0001, 32'h0, 1);  // R8 count 0
    step(1, 12, 32'h8000_0001, 32'h1F, 0); // R8 count 31
    step(1, 13, 32'h8000_0000, 32'h0, 1);  // R9 left through carry
    step(1, 14, 32'h0000_0001, 32'h0, 0);  // R9 right through carry
    step(1, 10, 32'h8000_0002, 32'h0, 0);  // R7 sign fill
    step(1, 11, 32'h8000_0003, 32'h0, 1);  // R7 zero fill
    step(1, 9, 32'hC000_0000, 32'h0, 0);   // R6
    step(1, 15, 32'h0, 32'h0, 1);          // R12
    step(0, 0, 32'h0, 32'h0, 1);           // R11 idle
    // Corner sweep: every opcode, every corner pair, both carries.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int ci = 0; ci < 2; ci++)
            step(1, op, corners[i], corners[j], bit'(ci));
    // Random mix with idle cycles.
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 15));
      bit iss = ($urandom_range(0, 7) != 0);
      step(iss, op, $urandom, $urandom, bit'($urandom_range(0, 1)));
    end
    step(0, 0, 32'h0, 32'h0, 0);
    @(negedge clk);
    check_all();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule